// File: doc/BRIEF.md
# Adjustable Time-of-Day Counter Chain

This block keeps the time of day as four cascaded two-digit BCD fields: hundredths of a second, seconds, minutes and hours. The lowest field advances on a single-cycle 100 Hz enable. Each field passes a carry pulse to the next more significant field in the same cycle in which it wraps, so all four fields update together on one clock edge.

A set mode lets a user adjust the time with two push keys, both active low. Both keys are filtered by two flops that are sampled on a 200 Hz enable and cleared whenever the key is released. A rising edge of the filtered signal makes exactly one event. Each select event steps a two-bit mode through run, hours, minutes and seconds, then back to run. In an adjust mode, each adjust event adds one to the chosen field. The block drives a one-hot select vector and a six-bit blink mask that a display scanner uses to flash the two digits of the chosen field. The blink phase toggles on every blink enable.

The clock divider and the display scanner are outside the block. All rates arrive as single-cycle enables on the one system clock.

Top module: `tod_counter_chain`

## Requirements
- R1: A synchronous active-high reset clears all four fields to 00, returns the mode to run (field_sel 0000, blink_mask 111111) and clears the blink phase to 0.
- R2: The packed time output carries hours in bits 31:24, minutes in 23:16, seconds in 15:8 and hundredths in 7:0, each as two BCD digits. Hundredths step by one BCD count on every tick_100hz, from 00 up to 99 and then back to 00.
- R3: When hundredths wraps, seconds advance in the same edge. When seconds wraps, minutes advance. When minutes wraps, hours advance. Seconds and minutes count 00 to 59, hours count 00 to 23, and 23:59:59.99 followed by one tick gives 00:00:00.00.
- R4: A key press, meaning the key input held low, is recognised only when the key is seen low on two tick_200hz samples with no release between them. Releasing the key (input high) clears the filter. One press gives exactly one event, however long the key is held.
- R5: Select events step the mode run, hours, minutes, seconds, run. The field_sel output is 0000, 1000, 0100 and 0010 for these modes, in that order, and is never 0001.
- R6: In run mode blink_mask is 111111. In any other mode, the two mask bits of the chosen field (5:4 hours, 3:2 minutes, 1:0 seconds) both equal the blink phase, and the other four bits are 0. The blink phase toggles on every tick_blink.
- R7: Each adjust event in an adjust mode adds one to the chosen field. At its limit the field wraps to 00, and this wrap sends no carry to the next field.
- R8: An adjust event in run mode changes no field.
- R9: Hundredths change only on tick_100hz, and an adjust event never changes them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_100hz | input | 1 | Single-cycle enable that advances hundredths |
| tick_200hz | input | 1 | Single-cycle enable that samples the keys |
| tick_blink | input | 1 | Single-cycle enable that toggles the blink phase |
| sel_key_n | input | 1 | Raw select key, low while pressed |
| adj_key_n | input | 1 | Raw adjust key, low while pressed |
| time_bcd | output | 32 | Packed BCD time (hours, minutes, seconds, hundredths) |
| field_sel | output | 4 | One-hot field select (bit 3 hours, 2 minutes, 1 seconds) |
| blink_mask | output | 6 | Digit blink mask for the display scanner |

## Verification
The assertions assume that the key inputs are synchronous to clk and that the enables are single-cycle pulses. They also assume an adjust event never falls in the same cycle as a carry into the chosen field. If it did, the two requests would merge into one increment, and the wrap and no-carry properties would not describe the result.

The bench keeps within these assumptions. It drives every input at the falling edge and pulses each tick for one cycle. It never raises tick_100hz while a key press is in progress. Every field state needed to exercise the carry and wrap corners is reached by manual adjustment.

// File: rtl/tod_pkg.sv
package tod_pkg;

    localparam int NUM_FIELDS = 4;
    localparam int FIELD_W    = 8;
    localparam int TIME_W     = NUM_FIELDS * FIELD_W;
    localparam int MASK_W     = 2 * (NUM_FIELDS - 1);

    typedef logic [FIELD_W-1:0] bcd_t;

    typedef enum logic [1:0] {
        MODE_RUN     = 2'd0,
        MODE_HOURS   = 2'd1,
        MODE_MINUTES = 2'd2,
        MODE_SECONDS = 2'd3
    } set_mode_e;

    typedef struct packed {
        logic first;
        logic second;
        logic last_level;
    } key_state_t;

    // Largest BCD value held by field idx (0 = hundredths ... 3 = hours)
    function automatic bcd_t field_limit(input int idx);
        case (idx)
            0:       return 8'h99;
            1, 2:    return 8'h59;
            default: return 8'h23;
        endcase
    endfunction

    function automatic bcd_t bcd_next(input bcd_t v, input bcd_t lim);
        if (v == lim)
            return '0;
        if (v[3:0] == 4'd9)
            return {v[7:4] + 4'd1, 4'd0};
        return {v[7:4], v[3:0] + 4'd1};
    endfunction

    function automatic logic bcd_in_range(input bcd_t v, input bcd_t lim);
        return (v[3:0] <= 4'd9) && (v <= lim);
    endfunction

    function automatic logic [NUM_FIELDS-1:0] mode_to_select(input set_mode_e m);
        if (m == MODE_RUN)
            return '0;
        return NUM_FIELDS'(1) << (NUM_FIELDS - int'(m));
    endfunction

endpackage

// File: rtl/tod_key_filter.sv
module tod_key_filter
    import tod_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic sample_en,
    input  logic key_n,
    output logic press_evt
);
    key_state_t st;
    logic       level;

    assign level     = st.first & st.second;
    assign press_evt = level & ~st.last_level;

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else begin
            st.last_level <= level;
            if (key_n) begin
                st.first  <= 1'b0;
                st.second <= 1'b0;
            end else if (sample_en) begin
                st.first  <= 1'b1;
                st.second <= st.first;
            end
        end
    end
endmodule

// File: rtl/tod_mode_ctrl.sv
module tod_mode_ctrl
    import tod_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  step_evt,
    input  logic                  blink_en,
    output logic [NUM_FIELDS-1:0] field_sel,
    output logic [MASK_W-1:0]     blink_mask
);
    set_mode_e mode;
    logic      phase;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode  <= MODE_RUN;
            phase <= 1'b0;
        end else begin
            if (step_evt)
                mode <= set_mode_e'(mode + 2'd1);
            if (blink_en)
                phase <= ~phase;
        end
    end

    assign field_sel = mode_to_select(mode);

    for (genvar i = 1; i < NUM_FIELDS; i++) begin : g_mask
        assign blink_mask[2*i-1 -: 2] = (mode == MODE_RUN) ? 2'b11
                                      : {2{field_sel[i] & phase}};
    end
endmodule

// File: rtl/tod_bcd_field.sv
module tod_bcd_field
    import tod_pkg::*;
#(
    parameter bcd_t LIMIT = 8'h59
) (
    input  logic clk,
    input  logic rst,
    input  logic carry_in,
    input  logic adjust,
    output bcd_t value,
    output logic carry_out
);
    logic at_limit;

    assign at_limit  = (value == LIMIT);
    assign carry_out = carry_in & at_limit;

    always_ff @(posedge clk) begin
        if (rst)
            value <= '0;
        else if (carry_in || adjust)
            value <= bcd_next(value, LIMIT);
    end
endmodule

// File: rtl/tod_counter_chain.sv
module tod_counter_chain
    import tod_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  tick_100hz,
    input  logic                  tick_200hz,
    input  logic                  tick_blink,
    input  logic                  sel_key_n,
    input  logic                  adj_key_n,
    output logic [TIME_W-1:0]     time_bcd,
    output logic [NUM_FIELDS-1:0] field_sel,
    output logic [MASK_W-1:0]     blink_mask
);
    logic                sel_evt;
    logic                adj_evt;
    logic [NUM_FIELDS:0] carry;

    tod_key_filter u_sel_key (
        .clk(clk), .rst(rst), .sample_en(tick_200hz),
        .key_n(sel_key_n), .press_evt(sel_evt)
    );

    tod_key_filter u_adj_key (
        .clk(clk), .rst(rst), .sample_en(tick_200hz),
        .key_n(adj_key_n), .press_evt(adj_evt)
    );

    tod_mode_ctrl u_mode (
        .clk(clk), .rst(rst), .step_evt(sel_evt), .blink_en(tick_blink),
        .field_sel(field_sel), .blink_mask(blink_mask)
    );

    assign carry[0] = tick_100hz;

    for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
        tod_bcd_field #(.LIMIT(field_limit(i))) u_field (
            .clk(clk),
            .rst(rst),
            .carry_in(carry[i]),
            .adjust(adj_evt & field_sel[i]),
            .value(time_bcd[FIELD_W*i +: FIELD_W]),
            .carry_out(carry[i+1])
        );
    end
endmodule

// File: rtl/tod_checker.sv
module tod_checker
    import tod_pkg::*;
(
    input logic                  clk,
    input logic                  rst,
    input logic                  tick_100hz,
    input logic                  sel_evt,
    input logic                  adj_evt,
    input logic [TIME_W-1:0]     time_bcd,
    input logic [NUM_FIELDS-1:0] field_sel,
    input logic [MASK_W-1:0]     blink_mask
);
    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (time_bcd == '0 && field_sel == '0)); // R1

    AST_FIELDS_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        bcd_in_range(time_bcd[7:0], 8'h99) && bcd_in_range(time_bcd[15:8], 8'h59) &&
        bcd_in_range(time_bcd[23:16], 8'h59) && bcd_in_range(time_bcd[31:24], 8'h23)); // R3

    AST_SEC_CARRY: assert property (@(posedge clk) disable iff (rst)
        (tick_100hz && time_bcd[7:0] == 8'h99 && !field_sel[1])
        |=> time_bcd[15:8] == bcd_next($past(time_bcd[15:8]), 8'h59)); // R3

    AST_ONE_EVENT: assert property (@(posedge clk) disable iff (rst)
        (sel_evt |=> !sel_evt) and (adj_evt |=> !adj_evt)); // R4

    AST_MODE_STEP: assert property (@(posedge clk) disable iff (rst)
        (sel_evt && field_sel == 4'b0000) |=> field_sel == 4'b1000); // R5

    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(field_sel) && !field_sel[0]); // R5

    AST_MASK_RUN: assert property (@(posedge clk) disable iff (rst)
        (field_sel == '0) |-> blink_mask == 6'b111111); // R6

    AST_MASK_PAIR: assert property (@(posedge clk) disable iff (rst)
        (field_sel != '0) |-> ($countones(blink_mask) == 0 || $countones(blink_mask) == 2)); // R6

    AST_ADJ_NO_CARRY: assert property (@(posedge clk) disable iff (rst)
        (adj_evt && field_sel[2] && time_bcd[23:16] == 8'h59 && !tick_100hz)
        |=> (time_bcd[23:16] == 8'h00 && $stable(time_bcd[31:24]))); // R7

    AST_RUN_ADJ_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (adj_evt && field_sel == '0 && !tick_100hz) |=> $stable(time_bcd)); // R8

    AST_HUND_HOLD: assert property (@(posedge clk) disable iff (rst)
        !tick_100hz |=> $stable(time_bcd[7:0])); // R9
endmodule

bind tod_counter_chain tod_checker u_tod_checker (
    .clk(clk), .rst(rst), .tick_100hz(tick_100hz),
    .sel_evt(sel_evt), .adj_evt(adj_evt),
    .time_bcd(time_bcd), .field_sel(field_sel), .blink_mask(blink_mask)
);

// File: tb/tod_counter_chain_bench.sv
module tod_counter_chain_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_100hz = 1'b0;
    logic        tick_200hz = 1'b0;
    logic        tick_blink = 1'b0;
    logic        sel_key_n = 1'b1;
    logic        adj_key_n = 1'b1;
    logic [31:0] time_bcd;
    logic [3:0]  field_sel;
    logic [5:0]  blink_mask;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    tod_counter_chain u_tod_counter_chain (
        .clk(clk), .rst(rst), .tick_100hz(tick_100hz), .tick_200hz(tick_200hz),
        .tick_blink(tick_blink), .sel_key_n(sel_key_n), .adj_key_n(adj_key_n),
        .time_bcd(time_bcd), .field_sel(field_sel), .blink_mask(blink_mask)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick100(input int n);
        for (int k = 0; k < n; k++) begin
            tick_100hz = 1'b1;
            @(negedge clk);
            tick_100hz = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic blink_pulse();
        tick_blink = 1'b1;
        @(negedge clk);
        tick_blink = 1'b0;
        @(negedge clk);
    endtask

    // which = 1 select key, 0 adjust key; samples = 200 Hz ticks while held
    task automatic press(input bit which, input int samples);
        if (which) sel_key_n = 1'b0; else adj_key_n = 1'b0;
        for (int k = 0; k < samples; k++) begin
            tick_200hz = 1'b1;
            @(negedge clk);
            tick_200hz = 1'b0;
            @(negedge clk);
        end
        @(negedge clk);
        sel_key_n = 1'b1;
        adj_key_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic press_n(input bit which, input int n);
        for (int k = 0; k < n; k++) press(which, 2);
    endtask

    task automatic t_reset();
        check("R1 time", time_bcd, 32'h0);
        check("R1 field_sel", {28'h0, field_sel}, 32'h0);
        check("R1 blink_mask", {26'h0, blink_mask}, 32'h3f);
    endtask

    task automatic t_hundredths();
        tick100(5);
        check("R2 five ticks", time_bcd, 32'h00000005);
        tick100(5);
        check("R2 BCD digit carry", time_bcd, 32'h00000010);
        repeat (10) @(negedge clk);
        check("R9 hold without tick", time_bcd, 32'h00000010);
        tick100(89);
        check("R2 reach 99", time_bcd, 32'h00000099);
        tick100(1);
        check("R3 carry into seconds", time_bcd, 32'h00000100);
    endtask

    task automatic t_filter();
        press(1'b1, 1);
        check("R4 single sample ignored", {28'h0, field_sel}, 32'h0);
        press(1'b0, 2);
        check("R8 adjust in run mode", time_bcd, 32'h00000100);
    endtask

    task automatic t_hours();
        press(1'b1, 2);
        check("R5 mode hours", {28'h0, field_sel}, 32'h8);
        check("R6 hours phase 0", {26'h0, blink_mask}, 32'h00);
        blink_pulse();
        check("R6 hours phase 1", {26'h0, blink_mask}, 32'h30);
        press_n(1'b0, 3);
        check("R7 hours adjust", time_bcd, 32'h03000100);
        press(1'b0, 6);
        check("R4 long hold one step", time_bcd, 32'h04000100);
    endtask

    task automatic t_minutes();
        press(1'b1, 2);
        check("R5 mode minutes", {28'h0, field_sel}, 32'h4);
        check("R6 minutes mask", {26'h0, blink_mask}, 32'h0c);
        press_n(1'b0, 59);
        check("R7 minutes to 59", time_bcd, 32'h04590100);
        press(1'b0, 2);
        check("R7 manual wrap no carry", time_bcd, 32'h04000100);
        press_n(1'b0, 59);
        check("R7 minutes back to 59", time_bcd, 32'h04590100);
    endtask

    task automatic t_seconds();
        press(1'b1, 2);
        check("R5 mode seconds", {28'h0, field_sel}, 32'h2);
        check("R6 seconds mask", {26'h0, blink_mask}, 32'h03);
        press_n(1'b0, 58);
        check("R7 seconds to 59", time_bcd, 32'h04595900);
        press(1'b1, 2);
        check("R5 wrap to run", {28'h0, field_sel}, 32'h0);
        check("R6 run mask", {26'h0, blink_mask}, 32'h3f);
    endtask

    task automatic t_day_wrap();
        press(1'b1, 2);
        press_n(1'b0, 19);
        check("R7 hours to 23", time_bcd, 32'h23595900);
        press_n(1'b1, 3);
        check("R5 back to run", {28'h0, field_sel}, 32'h0);
        tick100(99);
        check("R2 packed layout", time_bcd, 32'h23595999);
        tick100(1);
        check("R3 full day wrap", time_bcd, 32'h00000000);
    endtask

    task automatic t_reset_again();
        press(1'b1, 2);
        tick100(3);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_hundredths();
        t_filter();
        t_hours();
        t_minutes();
        t_seconds();
        t_day_wrap();
        t_reset_again();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule